// File: doc/BRIEF.md
# Display controller register bank

This block is the register file of a display controller. A host reaches it over a simple 32-bit word bus (one write or read strobe per cycle, byte offsets). It holds the graphics layer settings (base address, position, size, attributes, row and pixel increments), the panel sizes for two outputs (LCD and digital), background and transparency colours, a configuration word and a capability word. It also owns a 16-bit interrupt status/enable pair that drives one level-sensitive interrupt line.

Layer and panel settings are double buffered. Writes land in a shadow copy and read back from there. The hardware behind the block sees only an active copy, one per output, which is refreshed from the shadow copy when software sets that output's GO bit in the control word. A one-cycle dirty pulse tells the downstream pipeline that a setting which affects the picture was written. Raw event inputs set status bits. A palette-done input lets the load-mode field of the configuration word revert by itself. A soft reset written through the system-config word restores every default.

Top module: `dispc_regbank`

Register offsets: 0x00 system config, 0x04 interrupt status, 0x08 interrupt enable, 0x0C control, 0x10 config, 0x14 capability, 0x18/0x1C background colour 0/1, 0x20/0x24 transparency colour 0/1, 0x28 line number, 0x2C digital panel size, 0x30 LCD panel size, 0x34 layer base, 0x38 layer position, 0x3C layer size, 0x40 layer attributes, 0x44 row increment, 0x48 pixel increment.

## Requirements
- R1: `irq` is high exactly when (status AND enable) is non-zero, and it reflects a register change from the clock edge that made it.
- R2: A high `evt_in` bit sets the matching status bit. Writing status clears each bit written as 1 and leaves bits written as 0 alone. An event in the same cycle as a clear wins, so the bit stays set.
- R3: The interrupt enable register keeps only bits 15:0. Its other bits read back as 0.
- R4: The panel size registers and the layer size register hold width-minus-one in bits 10:0 and height-minus-one in bits 26:16. All other bits read 0, and each of these registers reads 0 after reset. The layer position register uses the same two fields.
- R5: A control write keeps the bits of mask 0x07FF9FFF. Bits 5 and 6 are one-shot strobes that read back as 0. Bit 0 drives `lcd_en` and bit 1 drives `dig_en` from the cycle after the write.
- R6: A control write with bit 6 set copies the shadow digital panel size, layer position, layer size and layer attributes to the digital active outputs. Bit 5 does the same for the LCD outputs, using the LCD panel size. Without a GO bit, shadow writes leave the active outputs unchanged.
- R7: Config keeps 14 bits. On a `palette_done` pulse, load mode (config bits 2:1) goes from 1 to 0 and from 3 to 2. Other values are unchanged. A config write in the same cycle wins.
- R8: Writing system config with bit 1 set performs a soft reset in the next cycle. Every register returns to its default: capability 0x161, row and pixel increment 1, and all others 0. Pending events in that cycle are dropped. Capability keeps 10 bits.
- R9: Layer attributes keep 11 bits. In the active copy, bit 0 is `*_layer_on` and bits 4:1 are `*_layer_fmt`.
- R10: The colour registers keep 24 bits, and the line-number register keeps 11 bits.
- R11: `dirty` is high for one cycle after a write to control, config, a colour, a panel size, layer base, position, size, attributes, or the row or pixel increment. It stays low after writes to the other registers.
- R12: A read returns data with `bus_rvalid` one cycle after `bus_rd`. A read of an unmapped offset returns 0 with `bus_err` high for that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid |
| bus_err | output | 1 | Unmapped read |
| evt_in | input | 16 | Raw interrupt events |
| palette_done | input | 1 | Palette load finished pulse |
| irq | output | 1 | Level interrupt |
| dirty | output | 1 | Picture setting changed pulse |
| lcd_en | output | 1 | LCD output enable |
| dig_en | output | 1 | Digital output enable |
| lcd_panel_size | output | 32 | Active LCD panel size image |
| dig_panel_size | output | 32 | Active digital panel size image |
| lcd_layer_pos | output | 32 | Active layer position, LCD |
| dig_layer_pos | output | 32 | Active layer position, digital |
| lcd_layer_size | output | 32 | Active layer size, LCD |
| dig_layer_size | output | 32 | Active layer size, digital |
| lcd_layer_fmt | output | 4 | Active pixel format, LCD |
| dig_layer_fmt | output | 4 | Active pixel format, digital |
| lcd_layer_on | output | 1 | Active layer enable, LCD |
| dig_layer_on | output | 1 | Active layer enable, digital |

## Verification
The hardest case to reach is an event and a status clear landing on the same clock edge. The stimulus reaches it by driving `evt_in` in the very cycle of a write-one-to-clear, so the set-wins rule of R2 can be observed on the interrupt line. A second case needs care: the two output copies must diverge. To get there, the stimulus refreshes the digital copy, rewrites the shadow attributes, then refreshes only the LCD copy, and checks that the two copies now hold different formats. The palette revert is driven from both load modes that change and from one that does not.

// File: rtl/dispc_regs_pkg.sv
package dispc_regs_pkg;

  localparam int PK_FMT_W = 4;

  // register offsets (byte addresses)
  localparam logic [7:0] A_SYSCFG = 8'h00;
  localparam logic [7:0] A_STAT   = 8'h04;
  localparam logic [7:0] A_IRQEN  = 8'h08;
  localparam logic [7:0] A_CTRL   = 8'h0C;
  localparam logic [7:0] A_CFG    = 8'h10;
  localparam logic [7:0] A_CAP    = 8'h14;
  localparam logic [7:0] A_BG0    = 8'h18;
  localparam logic [7:0] A_BG1    = 8'h1C;
  localparam logic [7:0] A_TR0    = 8'h20;
  localparam logic [7:0] A_TR1    = 8'h24;
  localparam logic [7:0] A_LINE   = 8'h28;
  localparam logic [7:0] A_SZDIG  = 8'h2C;
  localparam logic [7:0] A_SZLCD  = 8'h30;
  localparam logic [7:0] A_BASE   = 8'h34;
  localparam logic [7:0] A_POS    = 8'h38;
  localparam logic [7:0] A_LSIZE  = 8'h3C;
  localparam logic [7:0] A_ATTR   = 8'h40;
  localparam logic [7:0] A_ROWINC = 8'h44;
  localparam logic [7:0] A_PIXINC = 8'h48;

  localparam logic [31:0] CTRL_MASK   = 32'h07FF_9FFF;
  localparam int          GO_BASE_BIT = 5;  // bit 5 -> output 0 (LCD), bit 6 -> output 1 (digital)
  localparam logic [31:0] CAP_RESET   = 32'h0000_0161;
  localparam int          SRST_BIT    = 1;

  // one output's active settings
  typedef struct packed {
    logic [31:0]         panel;
    logic [31:0]         pos;
    logic [31:0]         size;
    logic [PK_FMT_W:0]   look;   // {format, layer on}
  } act_set_t;

endpackage

// File: rtl/dispc_irq.sv
module dispc_irq #(
  parameter int STAT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic [STAT_W-1:0] evt_in,
  input  logic              clr_we,
  input  logic              en_we,
  input  logic [STAT_W-1:0] wdata,
  output logic [STAT_W-1:0] stat,
  output logic [STAT_W-1:0] en,
  output logic              irq
);

  logic [STAT_W-1:0] stat_d, en_d;
  logic              stat_ce, en_ce;

  always_comb begin
    stat_ce = soft_rst | clr_we | (|evt_in);
    en_ce   = soft_rst | en_we;
    if (soft_rst) begin
      stat_d = '0;
      en_d   = '0;
    end else begin
      stat_d = (clr_we ? (stat & ~wdata) : stat) | evt_in;
      en_d   = en_we ? wdata : en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat <= '0;
      en   <= '0;
    end else begin
      if (stat_ce) stat <= stat_d;
      if (en_ce)   en   <= en_d;
    end
  end

  assign irq = |(stat & en);

endmodule

// File: rtl/dispc_act_bank.sv
module dispc_act_bank
  import dispc_regs_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     soft_rst,
  input  logic     go,
  input  act_set_t shd_in,
  output act_set_t act_out
);

  act_set_t act_d;
  logic     act_ce;

  always_comb begin
    act_ce = soft_rst | go;
    act_d  = soft_rst ? '0 : shd_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_out <= '0;
    else if (act_ce) act_out <= act_d;
  end

endmodule

// File: rtl/dispc_regbank.sv
module dispc_regbank
  import dispc_regs_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int STAT_W = 16,
  parameter int DIM_W  = 11,
  parameter int ATTR_W = 11,
  parameter int COL_W  = 24,
  parameter int CFG_W  = 14,
  parameter int CAP_W  = 10,
  parameter int LINE_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid,
  output logic              bus_err,
  input  logic [STAT_W-1:0] evt_in,
  input  logic              palette_done,
  output logic              irq,
  output logic              dirty,
  output logic              lcd_en,
  output logic              dig_en,
  output logic [31:0]       lcd_panel_size,
  output logic [31:0]       dig_panel_size,
  output logic [31:0]       lcd_layer_pos,
  output logic [31:0]       dig_layer_pos,
  output logic [31:0]       lcd_layer_size,
  output logic [31:0]       dig_layer_size,
  output logic [PK_FMT_W-1:0] lcd_layer_fmt,
  output logic [PK_FMT_W-1:0] dig_layer_fmt,
  output logic              lcd_layer_on,
  output logic              dig_layer_on
);

  localparam int          NUM_OUT   = 2;
  localparam logic [31:0] DIM_MASK  = 32'((64'd1 << DIM_W) - 1);
  localparam logic [31:0] SIZE_MASK = DIM_MASK | (DIM_MASK << 16);
  localparam logic [31:0] CTRL_KEEP = CTRL_MASK & ~(32'h3 << GO_BASE_BIT);

  // ---------------- reset synchronizer ----------------
  logic [1:0] rst_pipe;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_s = rst_pipe[1];

  function automatic logic at(input logic [ADDR_W-1:0] a, input logic [7:0] off);
    return a == ADDR_W'(off);
  endfunction

  // ---------------- write decode ----------------
  logic soft_rst, ctrl_wr, pic_wr;

  always_comb begin
    soft_rst = bus_wr & at(bus_addr, A_SYSCFG) & bus_wdata[SRST_BIT];
    ctrl_wr  = bus_wr & at(bus_addr, A_CTRL);
    pic_wr   = bus_wr & (at(bus_addr, A_CTRL)  | at(bus_addr, A_CFG)   |
                         at(bus_addr, A_BG0)   | at(bus_addr, A_BG1)   |
                         at(bus_addr, A_TR0)   | at(bus_addr, A_TR1)   |
                         at(bus_addr, A_SZDIG) | at(bus_addr, A_SZLCD) |
                         at(bus_addr, A_BASE)  | at(bus_addr, A_POS)   |
                         at(bus_addr, A_LSIZE) | at(bus_addr, A_ATTR)  |
                         at(bus_addr, A_ROWINC)| at(bus_addr, A_PIXINC));
  end

  // ---------------- shadow registers ----------------
  logic [31:0]       ctrl_q, ctrl_d;
  logic [CFG_W-1:0]  cfg_q, cfg_d;
  logic [CAP_W-1:0]  cap_q, cap_d;
  logic [COL_W-1:0]  bg0_q, bg0_d, bg1_q, bg1_d, tr0_q, tr0_d, tr1_q, tr1_d;
  logic [LINE_W-1:0] line_q, line_d;
  logic [31:0]       szdig_q, szdig_d, szlcd_q, szlcd_d;
  logic [31:0]       base_q, base_d, pos_q, pos_d, lsize_q, lsize_d;
  logic [ATTR_W-1:0] attr_q, attr_d;
  logic [31:0]       rowinc_q, rowinc_d, pixinc_q, pixinc_d;
  logic              reg_ce;

  always_comb begin
    reg_ce   = soft_rst | bus_wr | palette_done;
    ctrl_d   = ctrl_q;   cfg_d    = cfg_q;    cap_d    = cap_q;
    bg0_d    = bg0_q;    bg1_d    = bg1_q;    tr0_d    = tr0_q;
    tr1_d    = tr1_q;    line_d   = line_q;   szdig_d  = szdig_q;
    szlcd_d  = szlcd_q;  base_d   = base_q;   pos_d    = pos_q;
    lsize_d  = lsize_q;  attr_d   = attr_q;   rowinc_d = rowinc_q;
    pixinc_d = pixinc_q;
    if (soft_rst) begin
      ctrl_d   = '0;  cfg_d    = '0;  cap_d    = CAP_W'(CAP_RESET);
      bg0_d    = '0;  bg1_d    = '0;  tr0_d    = '0;  tr1_d = '0;
      line_d   = '0;  szdig_d  = '0;  szlcd_d  = '0;  base_d = '0;
      pos_d    = '0;  lsize_d  = '0;  attr_d   = '0;
      rowinc_d = 32'd1;  pixinc_d = 32'd1;
    end else begin
      if (palette_done && !(bus_wr && at(bus_addr, A_CFG))) begin
        case (cfg_q[2:1])
          2'b01:   cfg_d[2:1] = 2'b00;
          2'b11:   cfg_d[2:1] = 2'b10;
          default: ;
        endcase
      end
      if (bus_wr) begin
        case (bus_addr)
          ADDR_W'(A_CTRL):   ctrl_d   = bus_wdata & CTRL_KEEP;
          ADDR_W'(A_CFG):    cfg_d    = bus_wdata[CFG_W-1:0];
          ADDR_W'(A_CAP):    cap_d    = bus_wdata[CAP_W-1:0];
          ADDR_W'(A_BG0):    bg0_d    = bus_wdata[COL_W-1:0];
          ADDR_W'(A_BG1):    bg1_d    = bus_wdata[COL_W-1:0];
          ADDR_W'(A_TR0):    tr0_d    = bus_wdata[COL_W-1:0];
          ADDR_W'(A_TR1):    tr1_d    = bus_wdata[COL_W-1:0];
          ADDR_W'(A_LINE):   line_d   = bus_wdata[LINE_W-1:0];
          ADDR_W'(A_SZDIG):  szdig_d  = bus_wdata & SIZE_MASK;
          ADDR_W'(A_SZLCD):  szlcd_d  = bus_wdata & SIZE_MASK;
          ADDR_W'(A_BASE):   base_d   = bus_wdata;
          ADDR_W'(A_POS):    pos_d    = bus_wdata & SIZE_MASK;
          ADDR_W'(A_LSIZE):  lsize_d  = bus_wdata & SIZE_MASK;
          ADDR_W'(A_ATTR):   attr_d   = bus_wdata[ATTR_W-1:0];
          ADDR_W'(A_ROWINC): rowinc_d = bus_wdata;
          ADDR_W'(A_PIXINC): pixinc_d = bus_wdata;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      ctrl_q   <= '0;  cfg_q    <= '0;  cap_q    <= CAP_W'(CAP_RESET);
      bg0_q    <= '0;  bg1_q    <= '0;  tr0_q    <= '0;  tr1_q <= '0;
      line_q   <= '0;  szdig_q  <= '0;  szlcd_q  <= '0;  base_q <= '0;
      pos_q    <= '0;  lsize_q  <= '0;  attr_q   <= '0;
      rowinc_q <= 32'd1;  pixinc_q <= 32'd1;
    end else if (reg_ce) begin
      ctrl_q   <= ctrl_d;   cfg_q    <= cfg_d;    cap_q    <= cap_d;
      bg0_q    <= bg0_d;    bg1_q    <= bg1_d;    tr0_q    <= tr0_d;
      tr1_q    <= tr1_d;    line_q   <= line_d;   szdig_q  <= szdig_d;
      szlcd_q  <= szlcd_d;  base_q   <= base_d;   pos_q    <= pos_d;
      lsize_q  <= lsize_d;  attr_q   <= attr_d;   rowinc_q <= rowinc_d;
      pixinc_q <= pixinc_d;
    end
  end

  // ---------------- interrupt pair ----------------
  logic [STAT_W-1:0] stat, irq_en;

  dispc_irq #(.STAT_W(STAT_W)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .soft_rst (soft_rst),
    .evt_in   (evt_in),
    .clr_we   (bus_wr & at(bus_addr, A_STAT)),
    .en_we    (bus_wr & at(bus_addr, A_IRQEN)),
    .wdata    (bus_wdata[STAT_W-1:0]),
    .stat     (stat),
    .en       (irq_en),
    .irq      (irq)
  );

  // ---------------- active copies, one per output ----------------
  act_set_t shd [NUM_OUT];
  act_set_t act [NUM_OUT];

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_out
    assign shd[g].panel = (g == 0) ? szlcd_q : szdig_q;
    assign shd[g].pos   = pos_q;
    assign shd[g].size  = lsize_q;
    assign shd[g].look  = attr_q[PK_FMT_W:0];

    dispc_act_bank u_bank (
      .clk      (clk),
      .rst_n    (rst_n_s),
      .soft_rst (soft_rst),
      .go       (ctrl_wr & bus_wdata[GO_BASE_BIT + g] & ~soft_rst),
      .shd_in   (shd[g]),
      .act_out  (act[g])
    );
  end

  assign lcd_panel_size = act[0].panel;
  assign dig_panel_size = act[1].panel;
  assign lcd_layer_pos  = act[0].pos;
  assign dig_layer_pos  = act[1].pos;
  assign lcd_layer_size = act[0].size;
  assign dig_layer_size = act[1].size;
  assign lcd_layer_fmt  = act[0].look[PK_FMT_W:1];
  assign dig_layer_fmt  = act[1].look[PK_FMT_W:1];
  assign lcd_layer_on   = act[0].look[0];
  assign dig_layer_on   = act[1].look[0];
  assign lcd_en         = ctrl_q[0];
  assign dig_en         = ctrl_q[1];

  // ---------------- dirty pulse ----------------
  logic dirty_q;
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) dirty_q <= 1'b0;
    else          dirty_q <= pic_wr & ~soft_rst;
  end
  assign dirty = dirty_q;

  // ---------------- read path ----------------
  logic [31:0] rd_d;
  logic        rd_miss;

  always_comb begin
    rd_d    = '0;
    rd_miss = 1'b0;
    case (bus_addr)
      ADDR_W'(A_SYSCFG): rd_d = '0;
      ADDR_W'(A_STAT):   rd_d = 32'(stat);
      ADDR_W'(A_IRQEN):  rd_d = 32'(irq_en);
      ADDR_W'(A_CTRL):   rd_d = ctrl_q;
      ADDR_W'(A_CFG):    rd_d = 32'(cfg_q);
      ADDR_W'(A_CAP):    rd_d = 32'(cap_q);
      ADDR_W'(A_BG0):    rd_d = 32'(bg0_q);
      ADDR_W'(A_BG1):    rd_d = 32'(bg1_q);
      ADDR_W'(A_TR0):    rd_d = 32'(tr0_q);
      ADDR_W'(A_TR1):    rd_d = 32'(tr1_q);
      ADDR_W'(A_LINE):   rd_d = 32'(line_q);
      ADDR_W'(A_SZDIG):  rd_d = szdig_q;
      ADDR_W'(A_SZLCD):  rd_d = szlcd_q;
      ADDR_W'(A_BASE):   rd_d = base_q;
      ADDR_W'(A_POS):    rd_d = pos_q;
      ADDR_W'(A_LSIZE):  rd_d = lsize_q;
      ADDR_W'(A_ATTR):   rd_d = 32'(attr_q);
      ADDR_W'(A_ROWINC): rd_d = rowinc_q;
      ADDR_W'(A_PIXINC): rd_d = pixinc_q;
      default:           rd_miss = 1'b1;
    endcase
  end

  logic [31:0] rdata_q;
  logic        rvalid_q, err_q;

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      rdata_q  <= bus_rd ? rd_d : '0;
      rvalid_q <= bus_rd;
      err_q    <= bus_rd & rd_miss;
    end
  end

  assign bus_rdata  = rdata_q;
  assign bus_rvalid = rvalid_q;
  assign bus_err    = err_q;

endmodule

// File: rtl/dispc_regbank_chk.sv
module dispc_regbank_chk
  import dispc_regs_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int STAT_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic              bus_rvalid,
  input logic              bus_err,
  input logic [STAT_W-1:0] evt_in,
  input logic              irq,
  input logic              dirty,
  input logic              lcd_en,
  input logic              dig_en,
  input logic [31:0]       lcd_panel_size,
  input logic [31:0]       dig_panel_size,
  input logic [PK_FMT_W-1:0] lcd_layer_fmt,
  input logic [PK_FMT_W-1:0] dig_layer_fmt
);

  assert_clear_drops_irq_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(A_STAT) && bus_wdata[STAT_W-1:0] == '1 && evt_in == '0)
    |=> !irq);

  assert_read_ack_R12: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> bus_rvalid);

  assert_no_stray_ack_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> !bus_rvalid);

  assert_err_data_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> (bus_rvalid && bus_rdata == '0));

  assert_dirty_after_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    dirty |-> $past(bus_wr));

  assert_active_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> ($stable(lcd_panel_size) && $stable(dig_panel_size) &&
                 $stable(lcd_layer_fmt) && $stable(dig_layer_fmt)));

  assert_ctrl_enables_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(A_CTRL))
    |=> (lcd_en == $past(bus_wdata[0]) && dig_en == $past(bus_wdata[1])));

  assert_soft_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(A_SYSCFG) && bus_wdata[SRST_BIT])
    |=> (!irq && !lcd_en && !dig_en && lcd_panel_size == '0 && dig_panel_size == '0));

endmodule

bind dispc_regbank dispc_regbank_chk #(.ADDR_W(ADDR_W), .STAT_W(STAT_W)) u_chk (
  .rst_n(rst_n_s),
  .*
);

// File: tb/dispc_regbank_test.sv
module dispc_regbank_test;
  import dispc_regs_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr, bus_rd;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        bus_rvalid, bus_err;
  logic [15:0] evt_in;
  logic        palette_done;
  logic        irq, dirty, lcd_en, dig_en;
  logic [31:0] lcd_panel_size, dig_panel_size, lcd_layer_pos, dig_layer_pos;
  logic [31:0] lcd_layer_size, dig_layer_size;
  logic [3:0]  lcd_layer_fmt, dig_layer_fmt;
  logic        lcd_layer_on, dig_layer_on;

  int tests = 0;
  int fails = 0;

  logic [32:0] exp_q [$];
  string       tag_q [$];

  always #10 clk = ~clk;  // 50 MHz

  dispc_regbank uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .bus_err(bus_err), .evt_in(evt_in),
    .palette_done(palette_done), .irq(irq), .dirty(dirty),
    .lcd_en(lcd_en), .dig_en(dig_en),
    .lcd_panel_size(lcd_panel_size), .dig_panel_size(dig_panel_size),
    .lcd_layer_pos(lcd_layer_pos), .dig_layer_pos(dig_layer_pos),
    .lcd_layer_size(lcd_layer_size), .dig_layer_size(dig_layer_size),
    .lcd_layer_fmt(lcd_layer_fmt), .dig_layer_fmt(dig_layer_fmt),
    .lcd_layer_on(lcd_layer_on), .dig_layer_on(dig_layer_on)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  // driver: push expectation {err, data}, then issue the read
  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input logic exp_err, input string tag);
    exp_q.push_back({exp_err, exp});
    tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic pulse_palette();
    @(negedge clk); palette_done = 1'b1;
    @(negedge clk); palette_done = 1'b0;
  endtask

  // monitor: compare each returned read with the queue head
  always @(negedge clk) begin
    if (rst_n && bus_rvalid) begin
      if (exp_q.size() == 0) begin
        tests++; fails++;
        $display("FAIL R12 unexpected read data actual=%h expected=none", bus_rdata);
      end else begin
        logic [32:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(bus_rdata, e[31:0], t);
        check({31'd0, bus_err}, {31'd0, e[32]}, {t, " err"});
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
    evt_in = '0; palette_done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // reset state
    check({31'd0, irq}, 0, "R1 reset irq");
    check({31'd0, dirty}, 0, "R11 reset dirty");
    check({30'd0, dig_en, lcd_en}, 0, "R5 reset enables");
    check(dig_panel_size, 0, "R4 reset active size");
    rd(A_CAP, 32'h161, 1'b0, "R8 reset capability");
    rd(A_SZLCD, 32'h0, 1'b0, "R4 reset panel size");
    rd(A_LSIZE, 32'h0, 1'b0, "R4 reset layer size");
    rd(A_ROWINC, 32'h1, 1'b0, "R8 reset row increment");

    // R3 enable width
    wr(A_IRQEN, 32'hFFFF_00A5);
    check({31'd0, dirty}, 0, "R11 enable write no dirty");
    rd(A_IRQEN, 32'h0000_00A5, 1'b0, "R3 enable masked");

    // R1 / R2 events and clearing
    @(negedge clk); evt_in = 16'h0009;
    @(negedge clk); evt_in = '0;
    check({31'd0, irq}, 1, "R1 irq on enabled event");
    rd(A_STAT, 32'h9, 1'b0, "R2 status set by events");
    wr(A_STAT, 32'h1);
    check({31'd0, irq}, 0, "R1 irq low when pending bit disabled");
    rd(A_STAT, 32'h8, 1'b0, "R2 write-one clears only ones");
    wr(A_IRQEN, 32'h8);
    check({31'd0, irq}, 1, "R1 irq after enabling pending bit");
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = A_STAT; bus_wdata = 32'h8; evt_in = 16'h0008;
    @(negedge clk);
    bus_wr = 1'b0; evt_in = '0;
    check({31'd0, irq}, 1, "R2 event beats clear");
    wr(A_STAT, 32'hFFFF_FFFF);
    check({31'd0, irq}, 0, "R2 clear all");

    // R5 control
    wr(A_CTRL, 32'hFFFF_FFFF);
    check({31'd0, dirty}, 1, "R11 control write dirty");
    check({30'd0, dig_en, lcd_en}, 32'h3, "R5 both enables");
    rd(A_CTRL, 32'h07FF_9F9F, 1'b0, "R5 control mask and strobes");
    wr(A_CTRL, 32'h2);
    check({30'd0, dig_en, lcd_en}, 32'h2, "R5 digital only");

    // R4 / R6 / R9 shadow and GO
    wr(A_SZDIG, 32'hFFFF_FFFF);
    rd(A_SZDIG, 32'h07FF_07FF, 1'b0, "R4 size fields");
    wr(A_SZLCD, 32'h0123_0456);
    wr(A_POS, 32'h0010_0020);
    wr(A_LSIZE, 32'h00FF_013F);
    wr(A_ATTR, 32'hFFFF_FFFF);
    rd(A_ATTR, 32'h7FF, 1'b0, "R9 attributes 11 bits");
    check(dig_panel_size, 0, "R6 shadow not active before GO");
    check({28'd0, dig_layer_fmt}, 0, "R6 format not active before GO");
    wr(A_CTRL, 32'h40);
    check(dig_panel_size, 32'h07FF_07FF, "R6 digital GO panel");
    check(dig_layer_pos, 32'h0010_0020, "R6 digital GO position");
    check(dig_layer_size, 32'h00FF_013F, "R6 digital GO layer size");
    check({28'd0, dig_layer_fmt}, 32'hF, "R9 digital format");
    check({31'd0, dig_layer_on}, 1, "R9 digital layer on");
    check(lcd_panel_size, 0, "R6 LCD untouched by digital GO");
    rd(A_CTRL, 32'h0, 1'b0, "R5 GO bit reads zero");
    wr(A_ATTR, 32'h6);
    wr(A_CTRL, 32'h20);
    check(lcd_panel_size, 32'h0123_0456, "R6 LCD GO panel");
    check({28'd0, lcd_layer_fmt}, 32'h3, "R9 LCD format");
    check({31'd0, lcd_layer_on}, 0, "R9 LCD layer off");
    check({28'd0, dig_layer_fmt}, 32'hF, "R6 digital kept after LCD GO");

    // R10 widths, R11 dirty selectivity
    wr(A_BG0, 32'hFFFF_FFFF);
    check({31'd0, dirty}, 1, "R11 colour write dirty");
    @(negedge clk);
    check({31'd0, dirty}, 0, "R11 dirty lasts one cycle");
    rd(A_BG0, 32'h00FF_FFFF, 1'b0, "R10 colour 24 bits");
    wr(A_TR1, 32'hABCD_EF12);
    rd(A_TR1, 32'h00CD_EF12, 1'b0, "R10 transparency 24 bits");
    wr(A_LINE, 32'hFFFF_FFFF);
    check({31'd0, dirty}, 0, "R11 line write no dirty");
    rd(A_LINE, 32'h7FF, 1'b0, "R10 line 11 bits");
    wr(A_CAP, 32'hFFFF_FFFF);
    check({31'd0, dirty}, 0, "R11 capability write no dirty");
    rd(A_CAP, 32'h3FF, 1'b0, "R8 capability 10 bits");

    // R7 palette load mode
    wr(A_CFG, 32'hFFFF_FFFF);
    rd(A_CFG, 32'h3FFF, 1'b0, "R7 config 14 bits");
    wr(A_CFG, 32'h3);
    pulse_palette();
    rd(A_CFG, 32'h1, 1'b0, "R7 mode 1 reverts to 0");
    wr(A_CFG, 32'h6);
    pulse_palette();
    rd(A_CFG, 32'h4, 1'b0, "R7 mode 3 reverts to 2");
    pulse_palette();
    rd(A_CFG, 32'h4, 1'b0, "R7 mode 2 unchanged");

    // R12 unmapped read
    rd(8'hFC, 32'h0, 1'b1, "R12 unmapped read");
    rd(8'h4C, 32'h0, 1'b1, "R12 gap after last register");

    // R8 soft reset
    wr(A_IRQEN, 32'h1);
    @(negedge clk); evt_in = 16'h1;
    @(negedge clk); evt_in = '0;
    check({31'd0, irq}, 1, "R1 irq before soft reset");
    wr(A_CTRL, 32'h3);
    wr(A_SYSCFG, 32'h1);
    rd(A_CAP, 32'h3FF, 1'b0, "R8 bit 0 alone is no reset");
    wr(A_SYSCFG, 32'h2);
    check({31'd0, irq}, 0, "R8 irq after soft reset");
    check({30'd0, dig_en, lcd_en}, 0, "R8 enables after soft reset");
    check(dig_panel_size, 0, "R8 active size after soft reset");
    check({28'd0, dig_layer_fmt}, 0, "R8 active format after soft reset");
    rd(A_CAP, 32'h161, 1'b0, "R8 capability default");
    rd(A_SZDIG, 32'h0, 1'b0, "R8 panel size default");
    rd(A_IRQEN, 32'h0, 1'b0, "R8 enable default");
    rd(A_STAT, 32'h0, 1'b0, "R8 status default");
    rd(A_PIXINC, 32'h1, 1'b0, "R8 pixel increment default");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      tests++; fails++;
      $display("FAIL R12 missing read data actual=%0d expected=0", exp_q.size());
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule